// File: doc/BRIEF.md
# Go-Gated Two-Slot Handshake Queue

This block is a clocked model of a self-timed pipeline. It is a chain of storage links. Each link holds one data word and one occupancy bit. Joints sit between neighbouring links and move words along the chain. The default chain has two links and three joints:

- an entry joint that accepts a word from the producer into the first link;
- a middle joint that moves a word from the first link to the second;
- an exit joint that hands the last word to the consumer.

A joint acts only when three things hold together: every link it reads from is occupied, every link it writes to is vacant, and its own external permission bit is high.

The permission bits let a testbench, or a surrounding model, hold any joint back for any number of cycles. This reproduces the unpredictable event ordering of an asynchronous pipeline inside a synchronous simulation. Data is never transformed, only carried along.

When a joint acts, three things happen in the same clock edge: the word is copied forward, the destination link becomes occupied, and the source link becomes vacant. The producer watches the first link's vacancy and offers a word with a fill strobe. The consumer watches the last link's occupancy and takes the word with a drain strobe.

Top module: `gojoint_queue`

## Requirements
- R1: After reset every link is vacant: `inEmpty` reads 1, `outFull` reads 0 and `outData` reads 0.
- R2: The entry joint acts on an edge only when `inFill`, `go[0]` and `inEmpty` are all 1. A fill offered while the first link is occupied is ignored, and the stored word is kept unchanged.
- R3: A joint whose `go` bit is 0 does not act on that edge, even when its occupancy conditions hold. Bit j of `go` belongs to joint j, counted from the entry joint (bit 0) to the exit joint (bit DEPTH).
- R4: The middle joint j acts when link j-1 is occupied, link j is vacant and `go[j]` is 1. After that edge, link j-1 is vacant and link j holds the moved word.
- R5: The exit joint acts when `outDrain`, `go[DEPTH]` and `outFull` are all 1. After that edge the last link is vacant. A drain offered while the last link is vacant has no effect.
- R6: Words leave through `outData` in the order they were filled, with none lost and none repeated, whatever the pattern of `go` bits.
- R7: A vacant link holds zero, so `outData` reads 0 whenever `outFull` is 0.
- R8: With every `go` bit held at 1 and no word ahead of it, a word filled on edge k makes `outFull` 1 after edge k+DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | DEPTH+1 | Per-joint permission; bit 0 is the entry joint, bit DEPTH the exit joint |
| inFill | input | 1 | Producer offers `inData` |
| inData | input | WIDTH | Producer word |
| inEmpty | output | 1 | First link is vacant |
| outDrain | input | 1 | Consumer takes the last word |
| outData | output | WIDTH | Word in the last link (zero when vacant) |
| outFull | output | 1 | Last link is occupied |

## Verification
The hardest case to reach from the ports is a word held inside the chain while the joints around it are refused permission. In that state a fill into an occupied link, or a drain from a vacant one, must leave everything unchanged. Directed steps reach it by raising one `go` bit at a time, so the word parks in a chosen link before the blocked strobes are applied. A long random phase then toggles every `go` bit and both strobes each cycle. A scoreboard queue confirms that the output order matches the input order under these stalls.

// File: rtl/gojoint_pkg.sv
package gojoint_pkg;
  // Per-link strobes from control to datapath
  typedef struct packed {
    logic load;   // upstream joint acts: capture incoming word
    logic drain;  // downstream joint acts: clear to zero
  } linkStrobeT;
endpackage

// File: rtl/gojoint_ctrl.sv
module gojoint_ctrl
  import gojoint_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DEPTH:0]       go,
  input  logic                 inFill,
  input  logic                 outDrain,
  output logic                 inEmpty,
  output logic                 outFull,
  output linkStrobeT [DEPTH-1:0] strobes
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] fullQ;
  logic [DEPTH:0]   fire;

  // Entry and exit joints talk to the outside world
  assign fire[0]     = go[0] & inFill & ~fullQ[0];
  assign fire[DEPTH] = go[DEPTH] & outDrain & fullQ[LAST];

  // Inner joints: source occupied, destination vacant, permitted
  for (genvar j = 1; j < DEPTH; j++) begin : g_inner
    assign fire[j] = go[j] & fullQ[j-1] & ~fullQ[j];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_link
    assign strobes[i].load  = fire[i];
    assign strobes[i].drain = fire[i+1];
    always_ff @(posedge clk) begin
      if (!rstN) fullQ[i] <= 1'b0;
      else       fullQ[i] <= (fullQ[i] & ~fire[i+1]) | fire[i];
    end
  end

  assign inEmpty = ~fullQ[0];
  assign outFull = fullQ[LAST];
endmodule

// File: rtl/gojoint_data.sv
module gojoint_data
  import gojoint_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  linkStrobeT [DEPTH-1:0] strobes,
  input  logic [WIDTH-1:0]       inData,
  output logic [WIDTH-1:0]       outData
);
  logic [WIDTH-1:0] wordQ [DEPTH];
  logic [WIDTH-1:0] srcWord [DEPTH];

  assign srcWord[0] = inData;
  for (genvar i = 1; i < DEPTH; i++) begin : g_src
    assign srcWord[i] = wordQ[i-1];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)                 wordQ[i] <= '0;
      else if (strobes[i].load)  wordQ[i] <= srcWord[i];
      else if (strobes[i].drain) wordQ[i] <= '0;
    end
  end

  assign outData = wordQ[DEPTH-1];
endmodule

// File: rtl/gojoint_queue.sv
module gojoint_queue
  import gojoint_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH:0]   go,
  input  logic             inFill,
  input  logic [WIDTH-1:0] inData,
  output logic             inEmpty,
  input  logic             outDrain,
  output logic [WIDTH-1:0] outData,
  output logic             outFull
);
  linkStrobeT [DEPTH-1:0] strobes;

  gojoint_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .inFill(inFill), .outDrain(outDrain),
    .inEmpty(inEmpty), .outFull(outFull), .strobes(strobes)
  );

  gojoint_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/gojoint_queue_chk.sv
module gojoint_queue_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [DEPTH:0]   go,
  input logic             inFill,
  input logic             inEmpty,
  input logic             outDrain,
  input logic [WIDTH-1:0] outData,
  input logic             outFull
);
  a_r2_entry_acts: assert property (@(posedge clk) disable iff (!rstN)
    inEmpty && inFill && go[0] |=> !inEmpty);
  a_r2_stays_vacant: assert property (@(posedge clk) disable iff (!rstN)
    inEmpty && !(inFill && go[0]) |=> inEmpty);
  a_r3_held_entry_link: assert property (@(posedge clk) disable iff (!rstN)
    !inEmpty && !go[1] |=> !inEmpty);
  a_r5_exit_empties: assert property (@(posedge clk) disable iff (!rstN)
    outFull && outDrain && go[DEPTH] |=> !outFull);
  a_r5_last_held: assert property (@(posedge clk) disable iff (!rstN)
    outFull && !(outDrain && go[DEPTH]) |=> outFull && $stable(outData));
  a_r7_vacant_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outFull |-> outData == '0);
endmodule

bind gojoint_queue gojoint_queue_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .go(go), .inFill(inFill), .inEmpty(inEmpty),
  .outDrain(outDrain), .outData(outData), .outFull(outFull)
);

// File: tb/gojoint_queue_test.sv
`timescale 1ns/100ps
module gojoint_queue_test;
  localparam int WIDTH = 8;
  localparam int DEPTH = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DEPTH:0]   go = '0;
  logic             inFill = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic             inEmpty;
  logic             outDrain = 1'b0;
  logic [WIDTH-1:0] outData;
  logic             outFull;

  int checks = 0;
  int failures = 0;
  logic [WIDTH-1:0] expQ[$];
  logic [WIDTH-1:0] takenWord;
  int popped = 0;
  event takenEv;

  always #2.5 clk = ~clk;

  gojoint_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .go(go), .inFill(inFill), .inData(inData),
    .inEmpty(inEmpty), .outDrain(outDrain), .outData(outData), .outFull(outFull)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: compares each word the consumer takes
  initial begin
    forever begin
      @(takenEv);
      if (expQ.size() == 0) check("R6 extra word", {24'd0, takenWord}, 32'hFFFF);
      else check("R6 order", {24'd0, takenWord}, {24'd0, expQ.pop_front()});
      popped++;
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int sent;
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    check("R1 inEmpty", inEmpty, 1);
    check("R1 outFull", outFull, 0);
    check("R7 outData", outData, 0);

    // R3 entry joint refused
    inFill = 1; inData = 8'hA5; go = 3'b000;
    tick();
    check("R3 entry blocked", inEmpty, 1);
    // R2 entry joint permitted
    go = 3'b001;
    tick();
    check("R2 entry acts", inEmpty, 0);
    check("R2 not yet out", outFull, 0);
    // R2 fill into occupied link ignored; R3 middle refused
    inData = 8'h3C; go = 3'b001;
    tick();
    inFill = 0;
    check("R3 middle blocked", inEmpty, 0);
    // R4 middle joint moves the word
    go = 3'b010;
    tick();
    check("R4 source vacant", inEmpty, 1);
    check("R4 dest occupied", outFull, 1);
    check("R2 word kept", outData, 8'hA5);
    // R3 exit refused
    outDrain = 1; go = 3'b000;
    tick();
    check("R3 exit blocked", outFull, 1);
    check("R3 word stable", outData, 8'hA5);
    // R5 exit acts
    go = 3'b100;
    tick();
    check("R5 exit acts", outFull, 0);
    check("R7 zero when vacant", outData, 0);
    // R5 drain while vacant
    tick();
    outDrain = 0;
    check("R5 empty drain", outFull, 0);
    check("R5 empty drain in", inEmpty, 1);

    // R8 latency with all permissions
    go = '1; inFill = 1; inData = 8'h77;
    tick();
    inFill = 0;
    check("R8 after fill edge", outFull, 0);
    tick();
    check("R8 outFull", outFull, 1);
    check("R8 word", outData, 8'h77);
    outDrain = 1;
    tick();
    outDrain = 0;
    check("R5 latency drain", outFull, 0);

    // R6 random go patterns with scoreboard
    sent = 0;
    for (int c = 0; c < 4000; c++) begin
      go = $urandom();
      inFill = (sent < 1500) ? $urandom() % 2 : 0;
      inData = (sent * 37 + 11) % 256;
      outDrain = $urandom() % 2;
      #0.1;
      if (inFill && go[0] && inEmpty) begin
        expQ.push_back(inData);
        sent++;
      end
      if (outDrain && go[DEPTH] && outFull) begin
        takenWord = outData;
        ->takenEv;
      end
      tick();
    end
    // flush
    inFill = 0; go = '1; outDrain = 1;
    for (int c = 0; c < 10; c++) begin
      #0.1;
      if (outFull) begin
        takenWord = outData;
        ->takenEv;
      end
      tick();
    end
    check("R6 none lost", expQ.size(), 0);
    check("R6 count", popped, sent);
    finishRun();
  end
endmodule